// File: doc/BRIEF.md
# Host Command and Interrupt Status Core

This block sits between a host bus and the rest of a network adapter. The host writes a 16-bit command word to one port. The upper five bits select an operation and the lower eleven carry its argument. The block decodes the word and updates its own state: the selected register window, the receive and transmit enable flags, the interrupt mask and the latched interrupt causes. For every command it accepts, it also emits a one-cycle strobe that names the opcode, so the neighbouring datapaths can act on it.

The host reads back one 16-bit status word from the same offset. It holds the current window number in the top bits, a busy flag, and the eight latched causes in the low byte. Events from the media datapaths arrive as one-cycle cause pulses. The host clears latched causes with an acknowledge command, which carries a bit mask. A single interrupt line is raised whenever a latched cause is enabled in the mask.

The global reset command keeps the busy flag set for a parameterised number of cycles. While busy is set, both commands and cause pulses are ignored. All other commands finish in one cycle.

Top module: `csu_top`

## Requirements
- R1: After the synchronous reset input, status_word is 0x0000, irq is 0, rx_en and tx_en are 0, and op_strobe is 0.
- R2: An accepted command with opcode 1 (cmd_word[15:11]) loads cmd_word[2:0] as the window. From the cycle after the write, status_word[15:13] shows that window; argument bits 10 to 3 have no effect.
- R3: An accepted command with opcode 0x0D clears every latched cause bit i for which cmd_word[i] is 1. The cause bits are: 0 latch, 1 failure, 2 tx complete, 3 tx available, 4 rx complete, 5 rx early, 6 requested, 7 stats update. A cause being set in the same cycle takes priority over its clear.
- R4: status_word[7:0] holds the latched causes in that bit order, status_word[11:8] always reads 0, and status_word[12] is the busy flag.
- R5: An accepted command with opcode 0 clears the window, the causes, the mask, rx_en and tx_en in the cycle after the write. It also holds status_word[12] at 1 for exactly RESET_CYCLES consecutive cycles.
- R6: While status_word[12] is 1, cmd_valid and cause_in are ignored: no strobe is produced and no state changes.
- R7: A 1 on cause_in[i] for i in {1,2,3,4,5,7} sets cause bit i in the next cycle. cause_in[0] and cause_in[6] have no effect. An accepted command with opcode 0x0C sets cause bit 6.
- R8: An accepted command with opcode 0x0E loads cmd_word[7:0] as the interrupt mask. irq equals the OR of (latched causes AND mask) and follows any change in the cycle after it.
- R9: Cause bit 0 becomes set in the same cycle that any cause bit 1 to 7 is set while its mask bit is 1.
- R10: Opcode 4 sets rx_en and opcode 3 clears it. Opcode 9 sets tx_en and opcode 0x0A clears it.
- R11: Every accepted command drives op_strobe high for one cycle, with op_code equal to its opcode, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host write strobe for cmd_word |
| cmd_word | input | 16 | Opcode in bits 15:11, argument in bits 10:0 |
| cause_in | input | 8 | One-cycle event pulses from the datapaths, same bit order as the causes |
| status_word | output | 16 | Window, busy flag and latched causes |
| irq | output | 1 | Interrupt request |
| op_strobe | output | 1 | One-cycle pulse per accepted command |
| op_code | output | 5 | Opcode of the accepted command |
| rx_en | output | 1 | Receive enabled |
| tx_en | output | 1 | Transmit enabled |

## Verification
Every result, whether status bits, irq, the enable flags or the strobe, is registered once. Each is therefore due in the cycle after the clock edge that samples the command or pulse. The bench drives inputs on the falling edge and checks one full cycle later, on the next falling edge, so every check lands in the cycle the result is due. The busy window is measured by counting falling edges while the status busy bit is high, starting with the first cycle after the reset command, and the count is compared with RESET_CYCLES.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int CMD_W   = 16;
  localparam int OP_W    = 5;
  localparam int CAUSE_W = 8;
  localparam int WIN_W   = 3;

  localparam logic [OP_W-1:0] OP_GRESET = 5'h00;
  localparam logic [OP_W-1:0] OP_WINDOW = 5'h01;
  localparam logic [OP_W-1:0] OP_RX_OFF = 5'h03;
  localparam logic [OP_W-1:0] OP_RX_ON  = 5'h04;
  localparam logic [OP_W-1:0] OP_TX_ON  = 5'h09;
  localparam logic [OP_W-1:0] OP_TX_OFF = 5'h0A;
  localparam logic [OP_W-1:0] OP_RAISE  = 5'h0C;
  localparam logic [OP_W-1:0] OP_ACK    = 5'h0D;
  localparam logic [OP_W-1:0] OP_MASK   = 5'h0E;

  localparam int CAUSE_LATCH = 0;
  localparam int CAUSE_REQ   = 6;

  typedef struct packed {
    logic greset;
    logic window;
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic raise;
    logic ack;
    logic mask;
  } action_t;
endpackage

// File: rtl/csu_decode.sv
module csu_decode
  import csu_pkg::*;
(
  input  logic              valid,
  input  logic              busy,
  input  logic [CMD_W-1:0]  word,
  output logic              accept,
  output logic [OP_W-1:0]   opcode,
  output action_t           act
);
  assign accept = valid && !busy;
  assign opcode = word[CMD_W-1 -: OP_W];

  always_comb begin
    act        = '0;
    act.greset = accept && (opcode == OP_GRESET);
    act.window = accept && (opcode == OP_WINDOW);
    act.rx_on  = accept && (opcode == OP_RX_ON);
    act.rx_off = accept && (opcode == OP_RX_OFF);
    act.tx_on  = accept && (opcode == OP_TX_ON);
    act.tx_off = accept && (opcode == OP_TX_OFF);
    act.raise  = accept && (opcode == OP_RAISE);
    act.ack    = accept && (opcode == OP_ACK);
    act.mask   = accept && (opcode == OP_MASK);
  end
endmodule

// File: rtl/csu_busy_timer.sv
module csu_busy_timer #(
  parameter int RESET_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RESET_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= LOAD;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/csu_cause_bank.sv
module csu_cause_bank
  import csu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_all,
  input  logic [CAUSE_W-1:0] events,
  input  logic               raise,
  input  logic               ack,
  input  logic [CAUSE_W-1:0] ack_bits,
  input  logic               load_mask,
  input  logic [CAUSE_W-1:0] mask_val,
  output logic [CAUSE_W-1:0] causes,
  output logic               irq
);
  localparam logic [CAUSE_W-1:0] EXT_OK =
    ~((CAUSE_W'(1) << CAUSE_LATCH) | (CAUSE_W'(1) << CAUSE_REQ));

  logic [CAUSE_W-1:0] mask_q, sets, sets_all, clr, cause_d, mask_d;
  logic               hit;

  always_comb begin
    sets     = (events & EXT_OK) | (raise ? (CAUSE_W'(1) << CAUSE_REQ) : '0);
    hit      = |(sets & mask_q);
    sets_all = sets | (hit ? (CAUSE_W'(1) << CAUSE_LATCH) : '0);
    clr      = ack ? ack_bits : '0;
    cause_d  = clear_all ? '0 : ((causes & ~clr) | sets_all);
    mask_d   = clear_all ? '0 : (load_mask ? mask_val : mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      causes <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      causes <= cause_d;
      mask_q <= mask_d;
      irq    <= |(cause_d & mask_d);
    end
  end
endmodule

// File: rtl/csu_top.sv
module csu_top
  import csu_pkg::*;
#(
  parameter int RESET_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic [7:0]  cause_in,
  output logic [15:0] status_word,
  output logic        irq,
  output logic        op_strobe,
  output logic [4:0]  op_code,
  output logic        rx_en,
  output logic        tx_en
);
  localparam int RSV_W = CMD_W - WIN_W - 1 - CAUSE_W;

  logic               busy, accept;
  logic [OP_W-1:0]    opcode;
  action_t            act;
  logic [WIN_W-1:0]   window_q;
  logic [CAUSE_W-1:0] causes;

  csu_decode u_dec (
    .valid (cmd_valid),
    .busy  (busy),
    .word  (cmd_word),
    .accept(accept),
    .opcode(opcode),
    .act   (act)
  );

  csu_busy_timer #(.RESET_CYCLES(RESET_CYCLES)) u_busy (
    .clk  (clk),
    .rst  (rst),
    .start(act.greset),
    .busy (busy)
  );

  csu_cause_bank u_cause (
    .clk      (clk),
    .rst      (rst),
    .clear_all(act.greset),
    .events   (busy ? '0 : cause_in),
    .raise    (act.raise),
    .ack      (act.ack),
    .ack_bits (cmd_word[CAUSE_W-1:0]),
    .load_mask(act.mask),
    .mask_val (cmd_word[CAUSE_W-1:0]),
    .causes   (causes),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      window_q  <= '0;
      rx_en     <= 1'b0;
      tx_en     <= 1'b0;
      op_strobe <= 1'b0;
      op_code   <= '0;
    end else begin
      op_strobe <= accept;
      if (accept) op_code <= opcode;
      if (act.greset) begin
        window_q <= '0;
        rx_en    <= 1'b0;
        tx_en    <= 1'b0;
      end else begin
        if (act.window) window_q <= cmd_word[WIN_W-1:0];
        if (act.rx_on)  rx_en <= 1'b1;
        if (act.rx_off) rx_en <= 1'b0;
        if (act.tx_on)  tx_en <= 1'b1;
        if (act.tx_off) tx_en <= 1'b0;
      end
    end
  end

  assign status_word = {window_q, busy, {RSV_W{1'b0}}, causes};
endmodule

// File: rtl/csu_checker.sv
module csu_checker #(
  parameter int RESET_CYCLES = 1000
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic [15:0] cmd_word,
  input logic [7:0]  cause_in,
  input logic [15:0] status_word,
  input logic        irq,
  input logic        op_strobe,
  input logic [4:0]  op_code,
  input logic        rx_en,
  input logic        tx_en
);
  localparam int CW = $clog2(RESET_CYCLES + 2);

  logic           acc;
  logic [CW-1:0]  busy_run;
  assign acc = cmd_valid && !status_word[12];

  always_ff @(posedge clk) begin
    if (rst)                 busy_run <= '0;
    else if (status_word[12]) busy_run <= busy_run + 1'b1;
    else                     busy_run <= '0;
  end

  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    status_word[11:8] == 4'h0);

  a_r2_window_load: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_word[15:11] == 5'h01 |=> status_word[15:13] == $past(cmd_word[2:0]));

  a_r5_busy_starts: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_word[15:11] == 5'h00 |=> status_word[12] && status_word[7:0] == 8'h00);

  a_r5_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    int'(busy_run) <= RESET_CYCLES);

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_word[15:11] == 5'h0D && cause_in == 8'h00
    |=> (status_word[7:0] & $past(cmd_word[7:0])) == 8'h00);

  a_r6_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    status_word[12] && cmd_valid |=> !op_strobe);

  a_r11_strobe_source: assert property (@(posedge clk) disable iff (rst)
    op_strobe |-> $past(cmd_valid));

  a_r8_no_cause_no_irq: assert property (@(posedge clk) disable iff (rst)
    status_word[7:0] == 8'h00 |-> !irq);

  a_r10_rx_on: assert property (@(posedge clk) disable iff (rst)
    acc && cmd_word[15:11] == 5'h04 |=> rx_en);
endmodule

bind csu_top csu_checker #(.RESET_CYCLES(RESET_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .cause_in(cause_in), .status_word(status_word), .irq(irq),
  .op_strobe(op_strobe), .op_code(op_code), .rx_en(rx_en), .tx_en(tx_en)
);

// File: tb/csu_top_test.sv
module csu_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 6;

  typedef struct packed {
    logic        v;
    logic [15:0] cmd;
    logic [7:0]  cause;
    logic [15:0] st;
    logic        irq;
  } vec_t;

  // Walk: R2 R7 R8 R9 R3 R7 R7 R3 R8 R3 R2 R3
  localparam vec_t VECS [12] = '{
    '{1'b1, 16'h0D05, 8'h00, 16'hA000, 1'b0},
    '{1'b0, 16'h0000, 8'h10, 16'hA010, 1'b0},
    '{1'b1, 16'h7014, 8'h00, 16'hA010, 1'b1},
    '{1'b0, 16'h0000, 8'h04, 16'hA015, 1'b1},
    '{1'b1, 16'h6814, 8'h00, 16'hA001, 1'b0},
    '{1'b0, 16'h0000, 8'h41, 16'hA001, 1'b0},
    '{1'b1, 16'h6000, 8'h00, 16'hA041, 1'b0},
    '{1'b1, 16'h6841, 8'h08, 16'hA008, 1'b0},
    '{1'b1, 16'h70FF, 8'h00, 16'hA008, 1'b1},
    '{1'b1, 16'h6808, 8'h08, 16'hA009, 1'b1},
    '{1'b1, 16'h0802, 8'h00, 16'h4009, 1'b1},
    '{1'b1, 16'h68FF, 8'h00, 16'h4000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:0]  cause_in = '0;
  logic [15:0] status_word;
  logic        irq, op_strobe, rx_en, tx_en;
  logic [4:0]  op_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csu_top #(.RESET_CYCLES(RC)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cause_in(cause_in), .status_word(status_word), .irq(irq),
    .op_strobe(op_strobe), .op_code(op_code), .rx_en(rx_en), .tx_en(tx_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge with results due
  task automatic apply(input logic v, input logic [15:0] w, input logic [7:0] c);
    cmd_valid = v;
    cmd_word  = w;
    cause_in  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
    cause_in  = '0;
  endtask

  initial begin
    int busy_cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 status", 32'(status_word), 32'h0000);
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 rx_en", 32'(rx_en), 32'd0);
    check("R1 tx_en", 32'(tx_en), 32'd0);
    check("R1 strobe", 32'(op_strobe), 32'd0);

    for (int i = 0; i < 12; i++) begin
      apply(VECS[i].v, VECS[i].cmd, VECS[i].cause);
      check($sformatf("vec%0d status (R2/R3/R4/R7/R9)", i), 32'(status_word), 32'(VECS[i].st));
      check($sformatf("vec%0d irq (R8)", i), 32'(irq), 32'(VECS[i].irq));
    end

    // R10 and R11 enable flags and strobe
    apply(1'b1, 16'h2000, 8'h00);
    check("R10 rx_en on", 32'(rx_en), 32'd1);
    check("R11 strobe", 32'(op_strobe), 32'd1);
    check("R11 op_code", 32'(op_code), 32'h04);
    @(negedge clk);
    check("R11 strobe one cycle", 32'(op_strobe), 32'd0);
    apply(1'b1, 16'h4800, 8'h00);
    check("R10 tx_en on", 32'(tx_en), 32'd1);
    check("R11 op_code tx", 32'(op_code), 32'h09);
    apply(1'b1, 16'h1800, 8'h00);
    check("R10 rx_en off", 32'(rx_en), 32'd0);
    check("R10 tx_en kept", 32'(tx_en), 32'd1);
    apply(1'b1, 16'h5000, 8'h00);
    check("R10 tx_en off", 32'(tx_en), 32'd0);

    // R5 global reset; R6 inputs ignored while busy
    apply(1'b1, 16'h0803, 8'h00);
    apply(1'b1, 16'h70FF, 8'h00);
    apply(1'b1, 16'h2000, 8'h10);
    check("R5 pre state", 32'(status_word), 32'h6011);
    apply(1'b1, 16'h0000, 8'h00);
    check("R5 busy set and cleared", 32'(status_word), 32'h1000);
    check("R5 rx_en cleared", 32'(rx_en), 32'd0);
    check("R5 irq cleared", 32'(irq), 32'd0);
    apply(1'b1, 16'h0807, 8'h10);
    check("R6 window unchanged", 32'(status_word), 32'h1000);
    check("R6 no strobe", 32'(op_strobe), 32'd0);
    busy_cnt = 2;
    while (status_word[12] && busy_cnt < 100) begin
      @(negedge clk);
      if (status_word[12]) busy_cnt++;
    end
    check("R5 busy length", 32'(busy_cnt), 32'(RC));
    check("R5 after busy", 32'(status_word), 32'h0000);
    // mask cleared by reset: cause gives no irq
    apply(1'b0, 16'h0000, 8'h10);
    check("R5 mask cleared", 32'(irq), 32'd0);
    check("R7 cause after reset", 32'(status_word), 32'h0010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule